// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block holds the tag side of a set-associative cache: one valid bit, one dirty bit and one tag per way. It accepts one load or store address per handshake and decides whether the access hits. On a hit it reports the way. On a miss it reports the way that is filled, or that no fill takes place. Data storage and the real memory traffic sit elsewhere. The way to evict, once a set is full, comes in on `victim_way` from a separate replacement unit, which sees the same request.

Two static inputs set the store policy. One picks allocate-on-store-miss against bypass. The other picks write-back against write-through. For every access the controller adds a modelled cost to a running total, counting 1 for each cache access and `XFER_UNIT × ceil(LINE_BYTES/4)` for each memory transfer of a line. It also keeps separate counts of loads, stores and their hits and misses. `SETS` and `LINE_BYTES` must be powers of two.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The low log2(LINE_BYTES) address bits are a byte offset and are ignored. The set is (addr / LINE_BYTES) mod SETS. The tag is addr / (SETS × LINE_BYTES). With the defaults, addresses 0x000 and 0x00C share a line, and 0x010 lies in set 1 with the same tag as 0x000.
- R2: An access hits when a valid way of its set holds its tag. `rsp_hit` is then 1 and `rsp_way` gives the lowest such way.
- R3: A filling miss writes the lowest-numbered invalid way of the set. Only when all ways are valid does it use `victim_way`. `rsp_fill` is 1 and `rsp_way` names the filled way.
- R4: A load hit costs 1. A store hit costs 1, plus one transfer (T = 100 × ceil(LINE_BYTES/4) = 400 by default) under write-through. Under write-back it marks the line dirty and costs nothing more.
- R5: A load miss fills a line and costs T + 2. If the replaced way is dirty and write-back is selected, it first costs 1 + T more, `rsp_evict_dirty` is 1, and the new line is clean.
- R6: A store miss with bypass selected (`cfg_alloc`=0) costs exactly T. It sets `rsp_fill`=0 and leaves all valid, dirty and tag state as it was.
- R7: A store miss with `cfg_alloc`=1 fills and charges as in R5. It then adds T under write-through, or leaves the new line dirty under write-back.
- R8: `n_loads`, `n_stores`, `n_load_hit`, `n_load_miss`, `n_store_hit` and `n_store_miss` each count their class of accepted access.
- R9: `req_ready` is 1 whenever reset is low. An access is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its response, with `rsp_valid`=1, and its counter and total updates are visible right after that edge.
- R10: Synchronous reset drives `req_ready` low, clears every valid and dirty bit, and zeroes every counter, the total and `rsp_valid`.
- R11: `cycle_total` saturates at its all-ones value (CYC_W bits, 32 by default) and never wraps.
- R12: On an edge without an accepted request, `rsp_valid` is 0 and the counters and total are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_alloc | input | 1 | 1: allocate a line on store miss; 0: bypass |
| cfg_wback | input | 1 | 1: write-back; 0: write-through |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_store | input | 1 | 1: store, 0: load |
| req_addr | input | ADDR_W | Byte address |
| victim_way | input | WAY_W | Way to replace when the set is full |
| rsp_valid | output | 1 | Response for the access accepted on the previous edge |
| rsp_hit | output | 1 | Access hit |
| rsp_way | output | WAY_W | Hit or filled way (0 when neither) |
| rsp_fill | output | 1 | A line was allocated |
| rsp_evict_dirty | output | 1 | A dirty line was written back |
| n_loads | output | CNT_W | Loads accepted |
| n_stores | output | CNT_W | Stores accepted |
| n_load_hit | output | CNT_W | Load hits |
| n_load_miss | output | CNT_W | Load misses |
| n_store_hit | output | CNT_W | Store hits |
| n_store_miss | output | CNT_W | Store misses |
| cycle_total | output | CYC_W | Saturating modelled cost total |

## Verification
Every result here is due exactly one edge after acceptance: response flags, way, counters and total all register on the accepting edge. The bench therefore drives a request at a falling edge and checks its results at the next falling edge, while it drives the next request at the same moment. State changes, such as a line left dirty, a bypassed store, or a line cleared by reset, cannot be seen directly. They are exposed by a later access whose hit, way, eviction flag and cost are due one edge after that access is accepted. Saturation is checked at exact request counts on either side of the limit, with a narrowed total width.

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int CYC_W      = 32,
  parameter int XFER_UNIT  = 100,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_alloc,
  input  logic              cfg_wback,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WAY_W-1:0]  victim_way,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_fill,
  output logic              rsp_evict_dirty,
  output logic [CNT_W-1:0]  n_loads,
  output logic [CNT_W-1:0]  n_stores,
  output logic [CNT_W-1:0]  n_load_hit,
  output logic [CNT_W-1:0]  n_load_miss,
  output logic [CNT_W-1:0]  n_store_hit,
  output logic [CNT_W-1:0]  n_store_miss,
  output logic [CYC_W-1:0]  cycle_total
);
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int SET_BITS = $clog2(SETS);
  localparam int SET_W    = (SETS > 1) ? SET_BITS : 1;
  localparam int TAG_W    = ADDR_W - OFF_W - SET_BITS;
  localparam int CHUNKS   = (LINE_BYTES + 3) / 4;
  localparam int XFER     = XFER_UNIT * CHUNKS;

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic             accept;
  logic             hit, any_free, do_fill, evict_dirty;
  logic [WAY_W-1:0] hit_way, free_way, fill_way;
  logic [CYC_W-1:0] cost;
  logic [CYC_W:0]   sum;

  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;
  assign set_idx   = SET_W'((req_addr >> OFF_W) % ADDR_W'(SETS));
  assign req_tag   = TAG_W'(req_addr >> (OFF_W + SET_BITS));

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_q[set_idx][w] && tag_q[set_idx][w] == req_tag) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!valid_q[set_idx][w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign fill_way    = any_free ? free_way : victim_way;
  assign do_fill     = !hit && (!req_store || cfg_alloc);
  assign evict_dirty = do_fill && !any_free && cfg_wback && dirty_q[set_idx][victim_way];

  always_comb begin
    if (hit)
      cost = CYC_W'(1) + ((req_store && !cfg_wback) ? CYC_W'(XFER) : '0);
    else if (!do_fill)
      cost = CYC_W'(XFER);
    else
      cost = CYC_W'(XFER + 2)
           + (evict_dirty ? CYC_W'(XFER + 1) : '0)
           + ((req_store && !cfg_wback) ? CYC_W'(XFER) : '0);
  end

  assign sum = {1'b0, cycle_total} + {1'b0, cost};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (accept) begin
      if (hit && req_store && cfg_wback)
        dirty_q[set_idx][hit_way] <= 1'b1;
      if (do_fill) begin
        valid_q[set_idx][fill_way] <= 1'b1;
        dirty_q[set_idx][fill_way] <= req_store && cfg_wback;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && accept && do_fill)
      tag_q[set_idx][fill_way] <= req_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid       <= 1'b0;
      rsp_hit         <= 1'b0;
      rsp_way         <= '0;
      rsp_fill        <= 1'b0;
      rsp_evict_dirty <= 1'b0;
      n_loads         <= '0;
      n_stores        <= '0;
      n_load_hit      <= '0;
      n_load_miss     <= '0;
      n_store_hit     <= '0;
      n_store_miss    <= '0;
      cycle_total     <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit         <= hit;
        rsp_way         <= hit ? hit_way : (do_fill ? fill_way : '0);
        rsp_fill        <= do_fill;
        rsp_evict_dirty <= evict_dirty;
        cycle_total     <= sum[CYC_W] ? '1 : sum[CYC_W-1:0];
        if (req_store) begin
          n_stores <= n_stores + 1'b1;
          if (hit) n_store_hit  <= n_store_hit + 1'b1;
          else     n_store_miss <= n_store_miss + 1'b1;
        end else begin
          n_loads <= n_loads + 1'b1;
          if (hit) n_load_hit  <= n_load_hit + 1'b1;
          else     n_load_miss <= n_load_miss + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
  parameter int CNT_W = 16,
  parameter int CYC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fill,
  input logic             rsp_evict_dirty,
  input logic [CNT_W-1:0] n_loads,
  input logic [CNT_W-1:0] n_stores,
  input logic [CNT_W-1:0] n_load_hit,
  input logic [CNT_W-1:0] n_load_miss,
  input logic [CNT_W-1:0] n_store_hit,
  input logic [CNT_W-1:0] n_store_miss,
  input logic [CYC_W-1:0] cycle_total
);
  logic [CNT_W:0] total_acc;
  assign total_acc = {1'b0, n_loads} + {1'b0, n_stores};

  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (rst) req_ready); // R9
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid); // R9
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid); // R12
  AST_IDLE_TOTAL_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> $stable(cycle_total)); // R12
  AST_HIT_NEVER_FILLS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> !rsp_fill); // R3
  AST_EVICT_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_evict_dirty) |-> (rsp_fill && !rsp_hit)); // R5
  AST_TOTAL_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid) |-> cycle_total >= $past(cycle_total)); // R11
  AST_ONE_COUNT_PER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> total_acc == $past(total_acc) + 1'b1); // R8
  AST_LOAD_SPLIT: assert property (@(posedge clk) disable iff (rst)
    n_loads == CNT_W'(n_load_hit + n_load_miss)); // R8
  AST_STORE_SPLIT: assert property (@(posedge clk) disable iff (rst)
    n_stores == CNT_W'(n_store_hit + n_store_miss)); // R8
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(.CNT_W(CNT_W), .CYC_W(CYC_W)) chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fill(rsp_fill),
  .rsp_evict_dirty(rsp_evict_dirty), .n_loads(n_loads), .n_stores(n_stores),
  .n_load_hit(n_load_hit), .n_load_miss(n_load_miss), .n_store_hit(n_store_hit),
  .n_store_miss(n_store_miss), .cycle_total(cycle_total)
);

// File: tb/cache_tag_ctrl_test.sv
`timescale 1ns/1ps
module cache_tag_ctrl_test;
  localparam int CNT_W = 16;
  localparam int CYC_W = 16;
  localparam int NVEC  = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cfg_alloc, cfg_wback, req_valid, req_ready, req_store;
  logic [31:0] req_addr;
  logic victim_way;
  logic rsp_valid, rsp_hit, rsp_fill, rsp_evict_dirty;
  logic rsp_way;
  logic [CNT_W-1:0] n_loads, n_stores, n_load_hit, n_load_miss, n_store_hit, n_store_miss;
  logic [CYC_W-1:0] cycle_total;

  cache_tag_ctrl #(.SETS(4), .WAYS(2), .LINE_BYTES(16), .ADDR_W(32),
                   .CNT_W(CNT_W), .CYC_W(CYC_W), .XFER_UNIT(100)) uut (
    .clk(clk), .rst(rst), .cfg_alloc(cfg_alloc), .cfg_wback(cfg_wback),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_addr(req_addr), .victim_way(victim_way), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_fill(rsp_fill),
    .rsp_evict_dirty(rsp_evict_dirty), .n_loads(n_loads), .n_stores(n_stores),
    .n_load_hit(n_load_hit), .n_load_miss(n_load_miss), .n_store_hit(n_store_hit),
    .n_store_miss(n_store_miss), .cycle_total(cycle_total));

  typedef struct packed {
    logic        st;
    logic [31:0] addr;
    logic        vic;
    logic        alloc;
    logic        wback;
    logic        hit;
    logic        way;
    logic        fill;
    logic        ev;
    logic [15:0] cost;
  } vec_t;

  // store, addr, victim, alloc, wback | hit, way, fill, evict, cost
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 32'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd402},  // R3 free way0
    '{1'b0, 32'h00C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1},    // R1 R4
    '{1'b1, 32'h040, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd402},  // R7 wb
    '{1'b1, 32'h04C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1},    // R4 wb
    '{1'b0, 32'h080, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'd803},  // R5 dirty
    '{1'b0, 32'h080, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1},    // R2
    '{1'b1, 32'h000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd401},  // R4 wt
    '{1'b1, 32'h010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd400},  // R6
    '{1'b0, 32'h010, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd402},  // R1 R6 R3
    '{1'b1, 32'h040, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd402},  // R7 clean victim
    '{1'b1, 32'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd802},  // R7 wt
    '{1'b0, 32'h040, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1},    // R2
    '{1'b0, 32'h080, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'd803},  // R5
    '{1'b1, 32'h040, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd400},  // R6 wb
    '{1'b0, 32'h040, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd402},  // R3 victim
    '{1'b0, 32'h080, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1}     // R6 R2
  };

  int checks = 0;
  int errors = 0;
  logic [31:0] e_tot;
  int e_ld, e_st, e_lh, e_lm, e_sh, e_sm;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_counts(input string req);
    check(req, "n_loads", 32'(n_loads), 32'(e_ld));
    check(req, "n_stores", 32'(n_stores), 32'(e_st));
    check(req, "n_load_hit", 32'(n_load_hit), 32'(e_lh));
    check(req, "n_load_miss", 32'(n_load_miss), 32'(e_lm));
    check(req, "n_store_hit", 32'(n_store_hit), 32'(e_sh));
    check(req, "n_store_miss", 32'(n_store_miss), 32'(e_sm));
    check(req, "cycle_total", 32'(cycle_total), e_tot);
  endtask

  task automatic zero_model();
    e_tot = 0; e_ld = 0; e_st = 0; e_lh = 0; e_lm = 0; e_sh = 0; e_sm = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    zero_model();
    check("R10", "req_ready in reset", 32'(req_ready), 32'd0);
    check("R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check_counts("R10");
    rst = 1'b0;
    @(negedge clk);
    check("R9", "req_ready after reset", 32'(req_ready), 32'd1);
  endtask

  task automatic drive(input logic st, input logic [31:0] a, input logic v, input logic al, input logic wb);
    req_valid = 1'b1; req_store = st; req_addr = a; victim_way = v;
    cfg_alloc = al; cfg_wback = wb;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_addr = '0;
    victim_way = 1'b0; cfg_alloc = 1'b1; cfg_wback = 1'b1;
    repeat (2) @(negedge clk);
    do_reset();

    // Vector table, back-to-back requests; results sampled one edge later.
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].st, VEC[i].addr, VEC[i].vic, VEC[i].alloc, VEC[i].wback);
      @(negedge clk);
      e_tot = e_tot + 32'(VEC[i].cost);
      if (VEC[i].st) begin
        e_st++;
        if (VEC[i].hit) e_sh++; else e_sm++;
      end else begin
        e_ld++;
        if (VEC[i].hit) e_lh++; else e_lm++;
      end
      check("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
      check("R2", "rsp_hit", 32'(rsp_hit), 32'(VEC[i].hit));
      check("R3", "rsp_fill", 32'(rsp_fill), 32'(VEC[i].fill));
      check("R5", "rsp_evict_dirty", 32'(rsp_evict_dirty), 32'(VEC[i].ev));
      if (VEC[i].hit || VEC[i].fill)
        check("R3", "rsp_way", 32'(rsp_way), 32'(VEC[i].way));
      check_counts("R8");
    end

    // R12: idle edges change nothing
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R12", "rsp_valid idle", 32'(rsp_valid), 32'd0);
    check_counts("R12");

    // R10: reset invalidates lines that were resident
    do_reset();
    drive(1'b0, 32'h080, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    e_tot = 402; e_ld = 1; e_lm = 1;
    check("R10", "hit after reset", 32'(rsp_hit), 32'd0);
    check("R10", "fill way after reset", 32'(rsp_way), 32'd0);
    check_counts("R10");

    // R11: saturation of the total
    do_reset();
    drive(1'b1, 32'h010, 1'b0, 1'b0, 1'b0);
    repeat (163) @(negedge clk);
    e_tot = 65200; e_st = 163; e_sm = 163;
    check_counts("R11");
    @(negedge clk);
    e_tot = 65535; e_st = 164; e_sm = 164;
    check_counts("R11");
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    e_st = 170; e_sm = 170;
    check_counts("R11");
    @(negedge clk);
    check_counts("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule